// File: doc/BRIEF.md
# Control-Line Steered ALU

A combinational arithmetic-logic unit for a microcoded datapath. No opcode is decoded. Six independent control lines configure the unit:

- Two function lines pick one of four basic operations.
- Two gate lines can force either operand to zero.
- A flip line inverts the left operand after gating.
- A carry line injects a one into the least significant bit of the sum.

Mixing these lines gives the microprogram many useful results: constants, increment, decrement, negation and subtraction. None of them needs its own encoding.

Both operands arrive from the datapath buses. The unit returns a result of `W` bits, 32 by default, plus two status flags. The negative flag copies the result's most significant bit. The zero flag reports an all-zero result. Any carry out of the top bit is dropped. The shifter, register file, bus drivers and sequencer live outside this block.

Top module: `ctl_alu_core`

## Requirements
- R1: When `gate_left` is 0 the left operand is replaced by zero before any other processing.
- R2: When `gate_right` is 0 the right operand is replaced by zero.
- R3: When `flip_left` is 1 the gated left operand is bitwise inverted before the operation.
- R4: With function code {`fn0`,`fn1`} = 00 the result is the bitwise AND of the processed left and right operands.
- R5: With function code 01 the result is the bitwise OR of the processed operands.
- R6: With function code 10 the result is the bitwise inverse of the processed right operand, and the left operand has no effect.
- R7: With function code 11 the result is left + right + `carry_force`, taken modulo 2^W, with the carry out of the top bit discarded.
- R8: `carry_force` has no effect for function codes 00, 01 and 10.
- R9: `neg_flag` equals the most significant bit of `result`.
- R10: `zero_flag` is 1 exactly when every bit of `result` is 0.
- R11: Under code 11 the following control settings give the listed results:
  - `flip_left`, `carry_force`, both gates on: right − left.
  - `flip_left`, `carry_force`, left gate only: −left.
  - Left gate and `carry_force`, right gate off: left + 1.
  - Left gate off, `flip_left`, right gate on: right − 1.
  - All lines off: 0.
  - `carry_force` only: 1.
  - `flip_left` only: −1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_left | input | W | Left operand from the datapath |
| opnd_right | input | W | Right operand from the datapath |
| fn0 | input | 1 | Function select, high bit of the code |
| fn1 | input | 1 | Function select, low bit of the code |
| gate_left | input | 1 | 1 passes the left operand, 0 forces it to zero |
| gate_right | input | 1 | 1 passes the right operand, 0 forces it to zero |
| flip_left | input | 1 | Invert the gated left operand |
| carry_force | input | 1 | Carry into bit 0 of the sum |
| result | output | W | Operation result |
| neg_flag | output | 1 | Most significant bit of the result |
| zero_flag | output | 1 | Result is all zeros |

## Verification
The assertions run on every evaluation and check relations that must hold for any operand values:

- Both flags agree with the result.
- The AND output never sets a bit that the right operand lacks.
- The OR output keeps every bit of a gated-in right operand.
- The invert-right function follows only the right operand.
- A sum with both operands gated off equals the carry line.

Exact arithmetic values need the directed scenarios. These cover wraparound at the top bit, the subtraction and negation recipes, the constants, and the proof that the carry line leaves logical results unchanged.

// File: rtl/ctl_alu_pkg.sv
package ctl_alu_pkg;
  // Function code formed as {fn0, fn1}
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTR = 2'b10,
    FN_SUM  = 2'b11
  } alu_fn_e;

  function automatic alu_fn_e make_fn(input logic hi, input logic lo);
    return alu_fn_e'({hi, lo});
  endfunction
endpackage

// File: rtl/alu_operand_gate.sv
module alu_operand_gate #(
  parameter int W = 32
) (
  input  logic [W-1:0] left_in,
  input  logic [W-1:0] right_in,
  input  logic         gate_l,
  input  logic         gate_r,
  input  logic         flip_l,
  output logic [W-1:0] left_eff,
  output logic [W-1:0] right_eff
);
  logic [W-1:0] left_gated;

  always_comb begin
    left_gated = gate_l ? left_in : '0;
    left_eff   = flip_l ? ~left_gated : left_gated;
    right_eff  = gate_r ? right_in : '0;
  end
endmodule

// File: rtl/alu_func_core.sv
module alu_func_core
  import ctl_alu_pkg::*;
#(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] a_eff,
  input  logic [W-1:0] b_eff,
  input  alu_fn_e      fn,
  input  logic         cin,
  output logic [W-1:0] res
);
  logic [W-1:0] sum;

  generate
    if (RIPPLE) begin : g_ripple
      logic [W-1:0] carry;
      assign carry[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a_eff[i] ^ b_eff[i] ^ carry[i];
        if (i < W - 1) begin : g_cy
          assign carry[i+1] = (a_eff[i] & b_eff[i]) | (carry[i] & (a_eff[i] ^ b_eff[i]));
        end
      end
    end else begin : g_behav
      assign sum = a_eff + b_eff + {{(W-1){1'b0}}, cin};
    end
  endgenerate

  always_comb begin
    unique case (fn)
      FN_AND:  res = a_eff & b_eff;
      FN_OR:   res = a_eff | b_eff;
      FN_NOTR: res = ~b_eff;
      FN_SUM:  res = sum;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_status_gen.sv
module alu_status_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  output logic         neg,
  output logic         zero
);
  localparam int MSB = W - 1;

  always_comb begin
    neg  = res[MSB];
    zero = ~|res;
  end
endmodule

// File: rtl/ctl_alu_core.sv
module ctl_alu_core
  import ctl_alu_pkg::*;
#(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] opnd_left,
  input  logic [W-1:0] opnd_right,
  input  logic         fn0,
  input  logic         fn1,
  input  logic         gate_left,
  input  logic         gate_right,
  input  logic         flip_left,
  input  logic         carry_force,
  output logic [W-1:0] result,
  output logic         neg_flag,
  output logic         zero_flag
);
  logic [W-1:0] left_eff;
  logic [W-1:0] right_eff;
  alu_fn_e      fn_code;

  assign fn_code = make_fn(fn0, fn1);

  alu_operand_gate #(.W(W)) u_gate (
    .left_in   (opnd_left),
    .right_in  (opnd_right),
    .gate_l    (gate_left),
    .gate_r    (gate_right),
    .flip_l    (flip_left),
    .left_eff  (left_eff),
    .right_eff (right_eff)
  );

  alu_func_core #(.W(W), .RIPPLE(RIPPLE)) u_func (
    .a_eff (left_eff),
    .b_eff (right_eff),
    .fn    (fn_code),
    .cin   (carry_force),
    .res   (result)
  );

  alu_status_gen #(.W(W)) u_stat (
    .res  (result),
    .neg  (neg_flag),
    .zero (zero_flag)
  );
endmodule

// File: rtl/ctl_alu_chk.sv
module ctl_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opnd_left,
  input logic [W-1:0] opnd_right,
  input logic         fn0,
  input logic         fn1,
  input logic         gate_left,
  input logic         gate_right,
  input logic         flip_left,
  input logic         carry_force,
  input logic [W-1:0] result,
  input logic         neg_flag,
  input logic         zero_flag
);
  always_comb begin
    AST_NEG_IS_MSB: assert (neg_flag == result[W-1]) else $error("neg flag mismatch"); // R9
    AST_ZERO_FLAG: assert (zero_flag == (result == '0)) else $error("zero flag mismatch"); // R10
    if ({fn0, fn1} == 2'b00) begin
      AST_AND_SUBSET: assert ((result & ~(gate_right ? opnd_right : '0)) == '0) else $error("and set extra bit"); // R4
    end
    if ({fn0, fn1} == 2'b01 && gate_right) begin
      AST_OR_SUPERSET: assert ((result & opnd_right) == opnd_right) else $error("or lost bit"); // R5
    end
    if ({fn0, fn1} == 2'b10) begin
      AST_NOTR_RIGHT_ONLY: assert (result == ~(gate_right ? opnd_right : '0)) else $error("not-right wrong"); // R6
    end
    if ({fn0, fn1} == 2'b11 && !gate_left && !flip_left && !gate_right) begin
      AST_SUM_CARRY_ONLY: assert (result == {{(W-1){1'b0}}, carry_force}) else $error("carry-only sum wrong"); // R7
    end
  end
endmodule

bind ctl_alu_core ctl_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_ctl_alu_core.sv
module tb_ctl_alu_core;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opnd_left, opnd_right;
  logic         fn0, fn1, gate_left, gate_right, flip_left, carry_force;
  logic [W-1:0] result;
  logic         neg_flag, zero_flag;
  int           n_checks;
  int           n_fail;
  bit           done;

  ctl_alu_core #(.W(W)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [W-1:0] A0 = 32'h1234_5678;
  localparam logic [W-1:0] B0 = 32'h0F0F_00FF;

  task automatic check(input string tag, input logic [W-1:0] exp_r);
    n_checks++;
    if (result !== exp_r || neg_flag !== exp_r[W-1] || zero_flag !== (exp_r == '0)) begin
      n_fail++;
      $display("FAIL %s: result=%h n=%b z=%b expected result=%h n=%b z=%b",
               tag, result, neg_flag, zero_flag, exp_r, exp_r[W-1], exp_r == '0);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] fc,
                       input logic ga, input logic gb, input logic fl, input logic ci);
    @(negedge clk);
    opnd_left = a; opnd_right = b; {fn0, fn1} = fc;
    gate_left = ga; gate_right = gb; flip_left = fl; carry_force = ci;
    #5;
  endtask

  task automatic t_reset;
    check("reset idle R4 R10", '0);
  endtask

  task automatic t_logic;
    drive(A0, B0, 2'b00, 1, 1, 0, 0); check("R4 and", 32'h0204_0078);
    drive(A0, B0, 2'b01, 1, 1, 0, 0); check("R5 or", 32'h1F3F_56FF);
    drive(A0, B0, 2'b10, 1, 1, 0, 0); check("R6 not right", 32'hF0F0_FF00);
    drive(32'hFFFF_FFFF, B0, 2'b10, 1, 1, 1, 0); check("R6 left ignored", 32'hF0F0_FF00);
  endtask

  task automatic t_gating;
    drive(A0, B0, 2'b01, 0, 1, 0, 0); check("R1 left gated", B0);
    drive(A0, B0, 2'b01, 1, 0, 0, 0); check("R2 right gated", A0);
    drive(A0, B0, 2'b01, 1, 1, 1, 0); check("R3 flip left or", 32'hEFCF_A9FF);
    drive(A0, B0, 2'b01, 0, 0, 1, 0); check("R3 flip after gate R9", 32'hFFFF_FFFF);
  endtask

  task automatic t_carry_logic;
    drive(A0, B0, 2'b00, 1, 1, 0, 1); check("R8 and carry", 32'h0204_0078);
    drive(A0, B0, 2'b01, 1, 1, 0, 1); check("R8 or carry", 32'h1F3F_56FF);
    drive(A0, B0, 2'b10, 1, 1, 0, 1); check("R8 not carry", 32'hF0F0_FF00);
  endtask

  task automatic t_sum;
    drive(A0, B0, 2'b11, 1, 1, 0, 0); check("R7 add", 32'h2143_5777);
    drive(A0, B0, 2'b11, 1, 1, 0, 1); check("R7 add carry", 32'h2143_5778);
    drive(32'hFFFF_FFFF, 32'h1, 2'b11, 1, 1, 0, 0); check("R7 wrap R10", '0);
    drive(32'h7FFF_FFFF, 32'h1, 2'b11, 1, 1, 0, 0); check("R7 R9 sign", 32'h8000_0000);
  endtask

  task automatic t_recipes;
    drive(A0, B0, 2'b11, 1, 1, 1, 1); check("R11 right minus left", 32'hFCDA_AA87);
    drive(A0, B0, 2'b11, 1, 0, 1, 1); check("R11 negate left", 32'hEDCB_A988);
    drive(A0, B0, 2'b11, 1, 0, 0, 1); check("R11 left plus one", 32'h1234_5679);
    drive(A0, B0, 2'b11, 0, 1, 1, 0); check("R11 right minus one", 32'h0F0F_00FE);
    drive(A0, B0, 2'b11, 0, 0, 0, 0); check("R11 const zero", '0);
    drive(A0, B0, 2'b11, 0, 0, 0, 1); check("R11 const one", 32'h1);
    drive(A0, B0, 2'b11, 0, 0, 1, 0); check("R11 const minus one", 32'hFFFF_FFFF);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    opnd_left = '0; opnd_right = '0; fn0 = 0; fn1 = 0;
    gate_left = 0; gate_right = 0; flip_left = 0; carry_force = 0;
    repeat (2) @(negedge clk);
    #5;
    t_reset();
    rst_n = 1'b1;
    t_logic();
    t_gating();
    t_carry_logic();
    t_sum();
    t_recipes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule